// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is a 32-bit up-counting timer with a programmable wrap limit and one compare channel. The count advances by one on every cycle in which the tick-enable input is high and counting is switched on. When the count reaches the wrap limit, the next tick returns it to zero. A compare event raises a sticky flag, which can request an interrupt and can drive an output-reference level.

The compare event normally fires on the tick where the count equals the compare value. If the compare value lies above the wrap limit, the count can never reach it. In that case the event fires on the tick where the count sits at the wrap limit, so the flag rises once per wrap period. The update-disable control does not mask this event.

A second sticky flag marks every wrap, unless update-disable is set. Software reads and writes five registers through a plain address/data port.

Register addresses:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | status | read/clear |
| 2 | wrap limit | read/write |
| 3 | compare | read/write |
| 4 | count | read-only |

Top module: `tmr_oc_channel`

## Requirements
- R1: Reset sets the following state:
  - count = 0
  - control = 0
  - both flags = 0
  - compare = 0
  - wrap limit = 32'hFFFF_FFFF
  - irq = 0
  - oc_ref = 0
- R2: The count increments by one on each cycle where tick_en = 1 and control bit 0 (count enable) = 1. In any other cycle the count holds.
- R3: A tick taken while count == wrap limit loads the count with 0. A wrap limit of L therefore gives a period of L+1 ticks.
- R4: When compare <= wrap limit, a tick taken while count == compare sets status bit 0 (compare flag).
- R5: When compare > wrap limit, a tick taken while count == wrap limit sets the compare flag. This happens exactly once per wrap period.
- R6: irq = (status bit 0 AND control bit 1) OR (status bit 1 AND control bit 2). With both enable bits at 0, irq stays 0.
- R7: Writing status with a bit at 0 clears that flag, and writing a bit at 1 leaves it unchanged. If a set event and a clear fall in the same cycle, the flag ends up set.
- R8: Each wrap sets status bit 1 (update flag) unless control bit 3 (update-disable) = 1. Update-disable has no effect on the compare flag.
- R9: Control bits [5:4] select the output-reference action applied on each compare event:

  | Bits [5:4] | Action on oc_ref |
  |---|---|
  | 00 | frozen, no change |
  | 01 | drive high |
  | 10 | drive low |
  | 11 | toggle |
- R10: A compare write takes effect from the next cycle, with no shadow copy.
- R11: rd_data returns the register selected by rd_addr combinationally. Unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count qualifier, one tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Interrupt request |
| oc_ref | output | 1 | Output-reference level |

## Verification
The assertions assume that tick_en is a per-cycle qualifier, with each high cycle counting as one tick. They also assume the wrap limit is never lowered beneath a count that is already running. Without that, the counter climbs past the limit and only returns to zero at the 32-bit rollover, and the increment and wrap properties would no longer describe one period.

The stimulus respects these assumptions. Every scenario starts from a reset, and the wrap limit and compare value are programmed before counting is enabled. The only register written while ticks are running is compare (for R10) or status (for R7). Same-cycle writes and ticks are applied on purpose, to exercise the set-over-clear priority.

// File: rtl/tmr_oc_channel.sv
module tmr_oc_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq,
  output logic         oc_ref
);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_LIM = 3'd2, A_CMP = 3'd3, A_CNT = 3'd4;

  logic [W-1:0] cnt, lim, cmp;
  logic [5:0]   ctrl;
  logic         cc_flag, upd_flag;

  wire cnt_en  = ctrl[0];
  wire cc_ie   = ctrl[1];
  wire upd_ie  = ctrl[2];
  wire upd_dis = ctrl[3];
  wire [1:0] oc_mode = ctrl[5:4];

  wire step    = cnt_en & tick_en;
  wire at_lim  = (cnt == lim);
  wire wrap    = step & at_lim;
  wire hit     = step & ((cmp > lim) ? at_lim : (cnt == cmp));
  wire st_wr   = wr_en & (wr_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      lim      <= '1;
      cmp      <= '0;
      ctrl     <= '0;
      cc_flag  <= 1'b0;
      upd_flag <= 1'b0;
      oc_ref   <= 1'b0;
    end else begin
      if (step) cnt <= at_lim ? '0 : cnt + 1'b1;
      if (wr_en && wr_addr == A_CTRL) ctrl <= wr_data[5:0];
      if (wr_en && wr_addr == A_LIM)  lim  <= wr_data;
      if (wr_en && wr_addr == A_CMP)  cmp  <= wr_data;
      cc_flag  <= hit | (cc_flag & ~(st_wr & ~wr_data[0]));
      upd_flag <= (wrap & ~upd_dis) | (upd_flag & ~(st_wr & ~wr_data[1]));
      if (hit) begin
        case (oc_mode)
          2'b01:   oc_ref <= 1'b1;
          2'b10:   oc_ref <= 1'b0;
          2'b11:   oc_ref <= ~oc_ref;
          default: oc_ref <= oc_ref;
        endcase
      end
    end
  end

  assign irq = (cc_flag & cc_ie) | (upd_flag & upd_ie);

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {{(W-6){1'b0}}, ctrl};
      A_STAT:  rd_data = {{(W-2){1'b0}}, upd_flag, cc_flag};
      A_LIM:   rd_data = lim;
      A_CMP:   rd_data = cmp;
      A_CNT:   rd_data = cnt;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_oc_channel_chk.sv
module tmr_oc_channel_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic [5:0]   ctrl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] lim,
  input logic [W-1:0] cmp,
  input logic         cc_flag,
  input logic         upd_flag,
  input logic         irq,
  input logic         oc_ref
);
  wire step = ctrl[0] & tick_en;

  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step && cnt != lim |=> cnt == $past(cnt) + 32'd1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step && cnt == lim |=> cnt == '0);
  assert_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && cmp <= lim && cnt == cmp |=> cc_flag);
  assert_overflow_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step && cmp > lim && cnt == lim |=> cc_flag);
  assert_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1] && !ctrl[2] |-> !irq);
  assert_upd_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[3] && !upd_flag |=> !upd_flag);
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[5:4] == 2'b00 |=> $stable(oc_ref));
endmodule

bind tmr_oc_channel tmr_oc_channel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl(ctrl), .cnt(cnt),
  .lim(lim), .cmp(cmp), .cc_flag(cc_flag), .upd_flag(upd_flag),
  .irq(irq), .oc_ref(oc_ref)
);

// File: tb/tmr_oc_channel_tb.sv
`timescale 1ns/1ps
module tmr_oc_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, oc_ref;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tmr_oc_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .oc_ref(oc_ref)
  );

  localparam int NV = 10;
  localparam int V_LIM[NV] = '{10, 10, 10, 10, 3, 3, 0, 7, 7, 100};
  localparam int V_CMP[NV] = '{ 5,  5, 20, 20, 0, 3, 0, 8, 8,  50};
  localparam int V_N  [NV] = '{ 5,  6, 10, 11, 1, 4, 2, 7, 20, 50};
  localparam int V_CNT[NV] = '{ 5,  6, 10,  0, 1, 0, 0, 7, 4,  50};
  localparam int V_CC [NV] = '{ 0,  1,  0,  1, 1, 1, 1, 0, 1,  0};
  localparam int V_UPD[NV] = '{ 0,  0,  0,  1, 0, 1, 1, 0, 1,  0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    do_reset();

    // R1 / R11 reset values
    rd(3'd4, v); chk("R1 count", v, 0);
    rd(3'd2, v); chk("R1 limit", v, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R1 status", v, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd3, v); chk("R1 compare", v, 0);
    rd(3'd7, v); chk("R11 unused addr", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 oc_ref", oc_ref, 0);

    // vector table: R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(3'd2, V_LIM[i]);
      wr(3'd3, V_CMP[i]);
      wr(3'd0, 32'h1);
      ticks(V_N[i]);
      rd(3'd4, v); chk($sformatf("R3 vec%0d count", i), v, V_CNT[i]);
      rd(3'd1, v);
      chk($sformatf("R4 R5 vec%0d cc flag", i), v[0], V_CC[i]);
      chk($sformatf("R8 vec%0d upd flag", i), v[1], V_UPD[i]);
    end

    // R2 count enable and tick gating
    do_reset();
    wr(3'd2, 100);
    ticks(5);
    rd(3'd4, v); chk("R2 disabled holds", v, 0);
    wr(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R2 no tick holds", v, 0);
    ticks(3);
    rd(3'd4, v); chk("R2 three ticks", v, 3);

    // R5 once per period, R8 update-disable
    do_reset();
    wr(3'd2, 9);
    wr(3'd3, 50);
    wr(3'd0, 32'h9);
    ticks(10);
    rd(3'd1, v); chk("R5 first overflow cc", v[0], 1);
    chk("R8 upd suppressed", v[1], 0);
    wr(3'd1, 0);
    ticks(9);
    rd(3'd1, v); chk("R5 no extra event", v[0], 0);
    ticks(1);
    rd(3'd1, v); chk("R5 second overflow cc", v[0], 1);

    // R6 interrupt gating
    chk("R6 irq masked", irq, 0);
    wr(3'd0, 32'hB);
    chk("R6 irq on cc", irq, 1);
    do_reset();
    wr(3'd2, 2);
    wr(3'd3, 100);
    wr(3'd0, 32'h5);
    ticks(3);
    chk("R6 irq on upd", irq, 1);
    rd(3'd1, v); chk("R8 upd set", v[1], 1);

    // R7 clear rules
    do_reset();
    wr(3'd2, 20);
    wr(3'd3, 3);
    wr(3'd0, 32'h1);
    ticks(3);
    rd(3'd1, v); chk("R7 before match", v[0], 0);
    tick_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 0;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(3'd1, v); chk("R7 set beats clear", v[0], 1);
    wr(3'd1, 32'h3);
    rd(3'd1, v); chk("R7 write one keeps", v[0], 1);
    wr(3'd1, 32'h2);
    rd(3'd1, v); chk("R7 write zero clears", v[0], 0);

    // R10 compare rewrite
    do_reset();
    wr(3'd2, 100);
    wr(3'd3, 50);
    wr(3'd0, 32'h1);
    ticks(10);
    wr(3'd3, 12);
    rd(3'd3, v); chk("R11 compare readback", v, 12);
    ticks(2);
    rd(3'd1, v); chk("R10 not yet", v[0], 0);
    ticks(1);
    rd(3'd1, v); chk("R10 new compare hit", v[0], 1);

    // R9 output-reference modes
    do_reset();
    wr(3'd2, 3);
    wr(3'd3, 1);
    wr(3'd0, 32'h1);
    ticks(8);
    chk("R9 frozen", oc_ref, 0);
    rd(3'd1, v); chk("R9 frozen flag still sets", v[0], 1);
    do_reset();
    wr(3'd2, 3);
    wr(3'd3, 1);
    wr(3'd0, 32'h31);
    ticks(4);
    chk("R9 toggle once", oc_ref, 1);
    ticks(4);
    chk("R9 toggle twice", oc_ref, 0);
    do_reset();
    wr(3'd2, 3);
    wr(3'd3, 1);
    wr(3'd0, 32'h11);
    ticks(2);
    chk("R9 drive high", oc_ref, 1);
    wr(3'd0, 32'h21);
    ticks(4);
    chk("R9 drive low", oc_ref, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule